// File: doc/BRIEF.md
# Low-Power Suspend Arbitration Controller

This block holds the power and clock state of a small microcontroller system. Software picks a base power mode (run, sleep, stop or standby) and a main-clock configuration: the source (low-frequency 32 kHz clock or internal high-speed oscillator), the oscillator frequency select, and the dividers for the main clock and the ultra-low-power clock. The block drives the clock-mux selects, the enable of the switchable memory domain (SRAM and flash), and a flag that says the low-power mode is actually in force.

Two asynchronous peripheral events can lift stop or standby for a while. A fast-clock request puts the whole clock tree on the high-speed oscillator at 32 MHz and leaves the memory domain off. A DMA trigger powers the memory domain and leaves the clock tree exactly as it was when the suspension began. A fast-clock request also speeds up run and sleep when the main clock is slower than 32 MHz. When both events are active the outputs combine them. When every event has cleared, the saved clock setting and domain state come back for one cycle before the low-power mode takes effect again.

Top module: `lp_suspend_ctrl`

## Requirements
- R1: With base mode stop (2) or standby (3), a synchronized fast-clock request suspends the mode: mclk_src_o = 1 (high-speed oscillator), hsosc_fsel_o = 0 (32 MHz code), mclk_div_o = 0 and ulp_div_o = 0 (divide by one).
- R2: A suspension caused only by a fast-clock request keeps pd_mem_en_o at 0.
- R3: In run (0) or sleep (1), a fast-clock request while cfg_src_i = 0 (low-frequency) or cfg_fsel_i is not 0 applies the R1 clock values, keeps pd_mem_en_o = 1 and does not report suspension.
- R4: In run or sleep with cfg_src_i = 1 and cfg_fsel_i = 0, a fast-clock request leaves every clock output equal to the configuration inputs and sets no status bit.
- R5: In stop or standby, a synchronized DMA trigger suspends the mode and drives pd_mem_en_o = 1.
- R6: During a suspension with no fast-clock request, the clock outputs hold the configuration captured when the suspension began, even if the configuration inputs change.
- R7: With both causes active in stop or standby, the outputs carry the R1 clock values together with pd_mem_en_o = 1.
- R8: Request and trigger inputs pass through a two-flop synchronizer; one clock edge after an input rises, no output has changed.
- R9: When all causes clear, there is exactly one restore cycle in which the clock outputs equal the saved configuration, pd_mem_en_o takes its base value and lp_active_o is 0; lp_active_o returns to 1 in the next cycle.
- R10: status_o bit 2 is the suspended flag, bit 1 the active DMA cause, bit 0 the active fast-clock override.
- R11: A DMA trigger in run or sleep has no effect: outputs follow the configuration, pd_mem_en_o = 1, status_o = 0.
- R12: After reset the clock outputs follow the configuration inputs, status_o = 0, pd_mem_en_o is 0 only in stop or standby, and lp_active_o is 1 only in stop or standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| base_mode_i | input | 2 | Base power mode: 0 run, 1 sleep, 2 stop, 3 standby |
| cfg_src_i | input | 1 | Configured main-clock source: 0 low-frequency, 1 high-speed oscillator |
| cfg_fsel_i | input | 2 | Configured oscillator frequency select, 0 = 32 MHz |
| cfg_mdiv_i | input | DIV_W | Configured main-clock divider code |
| cfg_udiv_i | input | DIV_W | Configured ultra-low-power clock divider code |
| fast_req_i | input | 1 | Asynchronous fast-clock request |
| dma_trig_i | input | 1 | Asynchronous DMA trigger |
| mclk_src_o | output | 1 | Main-clock source select |
| hsosc_fsel_o | output | 2 | Oscillator frequency select |
| mclk_div_o | output | DIV_W | Main-clock divider select |
| ulp_div_o | output | DIV_W | Ultra-low-power clock divider select |
| pd_mem_en_o | output | 1 | Switchable memory domain enable |
| lp_active_o | output | 1 | Low-power mode in force |
| status_o | output | 3 | {suspended, DMA cause, fast-clock cause} |

## Verification
The bench aims at the point where the two causes diverge: a design that powered the memory domain on a fast-clock request, or retuned the clock on a DMA trigger, shows the wrong enable or wrong selects during the suspension. It changes the configuration inputs in the middle of a DMA suspension, which a design that forgot the captured setting would pass straight to the outputs. It drops one cause of a joint suspension to catch a design that latches the union, samples the single restore cycle to catch a design that re-enters the low-power mode in the same cycle it restores the clocks, and looks one edge after a request to catch a missing synchronizer stage.

// File: rtl/lp_suspend_pkg.sv
package lp_suspend_pkg;
  typedef enum logic [1:0] {
    MODE_RUN     = 2'd0,
    MODE_SLEEP   = 2'd1,
    MODE_STOP    = 2'd2,
    MODE_STANDBY = 2'd3
  } pwr_mode_e;

  typedef enum logic [1:0] {
    ST_BASE    = 2'd0,
    ST_SUSP    = 2'd1,
    ST_RESTORE = 2'd2
  } susp_state_e;

  localparam logic       SRC_LF   = 1'b0;
  localparam logic       SRC_HS   = 1'b1;
  localparam logic [1:0] FSEL_32M = 2'd0;

  function automatic logic is_lp(input logic [1:0] mode);
    return mode[1];
  endfunction
endpackage

// File: rtl/lp_sync.sv
module lp_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) stg_q[i] <= stg_q[i-1];
      stg_q[0] <= d_i;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lp_susp_fsm.sv
module lp_susp_fsm
  import lp_suspend_pkg::*;
#(
  parameter int DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fast_s_i,
  input  logic             dma_s_i,
  input  logic [1:0]       base_mode_i,
  input  logic             cfg_src_i,
  input  logic [1:0]       cfg_fsel_i,
  input  logic [DIV_W-1:0] cfg_mdiv_i,
  input  logic [DIV_W-1:0] cfg_udiv_i,
  output susp_state_e      state_o,
  output logic [1:0]       sv_mode_o,
  output logic             sv_src_o,
  output logic [1:0]       sv_fsel_o,
  output logic [DIV_W-1:0] sv_mdiv_o,
  output logic [DIV_W-1:0] sv_udiv_o
);
  susp_state_e state_q, state_d;
  logic        wake;
  logic        any_req;

  assign any_req = fast_s_i | dma_s_i;
  assign wake    = is_lp(base_mode_i) & any_req;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_BASE:    if (wake) state_d = ST_SUSP;
      ST_SUSP:    if (!any_req) state_d = ST_RESTORE;
      ST_RESTORE: state_d = ST_BASE;
      default:    state_d = ST_BASE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_BASE;
      sv_mode_o <= '0;
      sv_src_o  <= SRC_LF;
      sv_fsel_o <= '0;
      sv_mdiv_o <= '0;
      sv_udiv_o <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_BASE && wake) begin
        // snapshot base setting at suspend entry
        sv_mode_o <= base_mode_i;
        sv_src_o  <= cfg_src_i;
        sv_fsel_o <= cfg_fsel_i;
        sv_mdiv_o <= cfg_mdiv_i;
        sv_udiv_o <= cfg_udiv_i;
      end
    end
  end

  assign state_o = state_q;

  AST_ENTRY_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SUSP && $past(state_q) == ST_BASE) |-> $past(any_req)); // R8

  AST_SNAPSHOT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SUSP && $past(state_q) == ST_SUSP) |->
      ($stable(sv_mdiv_o) && $stable(sv_udiv_o) && $stable(sv_src_o))); // R6

  AST_RESTORE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RESTORE) |=> (state_q == ST_BASE)); // R9
endmodule

// File: rtl/lp_clk_mux.sv
module lp_clk_mux
  import lp_suspend_pkg::*;
#(
  parameter int DIV_W = 3
) (
  input  logic             use_saved_i,
  input  logic             fast_i,
  input  logic             live_src_i,
  input  logic [1:0]       live_fsel_i,
  input  logic [DIV_W-1:0] live_mdiv_i,
  input  logic [DIV_W-1:0] live_udiv_i,
  input  logic             sv_src_i,
  input  logic [1:0]       sv_fsel_i,
  input  logic [DIV_W-1:0] sv_mdiv_i,
  input  logic [DIV_W-1:0] sv_udiv_i,
  output logic             src_o,
  output logic [1:0]       fsel_o,
  output logic [DIV_W-1:0] mdiv_o,
  output logic [DIV_W-1:0] udiv_o
);
  always_comb begin
    if (fast_i) begin
      src_o  = SRC_HS;
      fsel_o = FSEL_32M;
      mdiv_o = '0;
      udiv_o = '0;
    end else if (use_saved_i) begin
      src_o  = sv_src_i;
      fsel_o = sv_fsel_i;
      mdiv_o = sv_mdiv_i;
      udiv_o = sv_udiv_i;
    end else begin
      src_o  = live_src_i;
      fsel_o = live_fsel_i;
      mdiv_o = live_mdiv_i;
      udiv_o = live_udiv_i;
    end
  end
endmodule

// File: rtl/lp_suspend_ctrl.sv
module lp_suspend_ctrl
  import lp_suspend_pkg::*;
#(
  parameter int DIV_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       base_mode_i,
  input  logic             cfg_src_i,
  input  logic [1:0]       cfg_fsel_i,
  input  logic [DIV_W-1:0] cfg_mdiv_i,
  input  logic [DIV_W-1:0] cfg_udiv_i,
  input  logic             fast_req_i,
  input  logic             dma_trig_i,
  output logic             mclk_src_o,
  output logic [1:0]       hsosc_fsel_o,
  output logic [DIV_W-1:0] mclk_div_o,
  output logic [DIV_W-1:0] ulp_div_o,
  output logic             pd_mem_en_o,
  output logic             lp_active_o,
  output logic [2:0]       status_o
);
  localparam int NUM_REQ = 2;

  logic [NUM_REQ-1:0] req_s;
  logic               fast_s, dma_s;
  susp_state_e        state;
  logic [1:0]         sv_mode, sv_fsel;
  logic               sv_src;
  logic [DIV_W-1:0]   sv_mdiv, sv_udiv;
  logic               in_susp, use_saved, eff_lp, live_slow, fast_ovr, dma_act;
  logic [1:0]         eff_mode;

  lp_sync #(.WIDTH(NUM_REQ), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({dma_trig_i, fast_req_i}),
    .q_o   (req_s)
  );
  assign fast_s = req_s[0];
  assign dma_s  = req_s[1];

  lp_susp_fsm #(.DIV_W(DIV_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fast_s_i   (fast_s),
    .dma_s_i    (dma_s),
    .base_mode_i(base_mode_i),
    .cfg_src_i  (cfg_src_i),
    .cfg_fsel_i (cfg_fsel_i),
    .cfg_mdiv_i (cfg_mdiv_i),
    .cfg_udiv_i (cfg_udiv_i),
    .state_o    (state),
    .sv_mode_o  (sv_mode),
    .sv_src_o   (sv_src),
    .sv_fsel_o  (sv_fsel),
    .sv_mdiv_o  (sv_mdiv),
    .sv_udiv_o  (sv_udiv)
  );

  assign in_susp   = (state == ST_SUSP);
  assign use_saved = (state != ST_BASE);
  assign eff_mode  = use_saved ? sv_mode : base_mode_i;
  assign eff_lp    = is_lp(eff_mode);
  // main clock below 32 MHz from the live setting
  assign live_slow = (cfg_src_i == SRC_LF) | (cfg_fsel_i != FSEL_32M);
  assign fast_ovr  = fast_s & (in_susp |
                     ((state == ST_BASE) & ~is_lp(base_mode_i) & live_slow));
  assign dma_act   = in_susp & dma_s;

  lp_clk_mux #(.DIV_W(DIV_W)) u_mux (
    .use_saved_i(use_saved),
    .fast_i     (fast_ovr),
    .live_src_i (cfg_src_i),
    .live_fsel_i(cfg_fsel_i),
    .live_mdiv_i(cfg_mdiv_i),
    .live_udiv_i(cfg_udiv_i),
    .sv_src_i   (sv_src),
    .sv_fsel_i  (sv_fsel),
    .sv_mdiv_i  (sv_mdiv),
    .sv_udiv_i  (sv_udiv),
    .src_o      (mclk_src_o),
    .fsel_o     (hsosc_fsel_o),
    .mdiv_o     (mclk_div_o),
    .udiv_o     (ulp_div_o)
  );

  assign pd_mem_en_o = ~eff_lp | dma_act;
  assign lp_active_o = (state == ST_BASE) & is_lp(base_mode_i);
  assign status_o    = {in_susp, dma_act, fast_ovr};

  AST_FAST_32M: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[0] |-> (mclk_src_o == SRC_HS && hsosc_fsel_o == FSEL_32M &&
                     mclk_div_o == '0 && ulp_div_o == '0)); // R1

  AST_FAST_NO_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[2] && !status_o[1]) |-> !pd_mem_en_o); // R2

  AST_DMA_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[1] |-> (pd_mem_en_o && status_o[2])); // R5

  AST_HS32_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_active_o == 1'b0 && !is_lp(base_mode_i) && !status_o[2] && state == ST_BASE &&
     cfg_src_i == SRC_HS && cfg_fsel_i == FSEL_32M) |->
      (!status_o[0] && mclk_div_o == cfg_mdiv_i && ulp_div_o == cfg_udiv_i)); // R4

  AST_RESTORE_BEFORE_LP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[2]) |-> !lp_active_o); // R9

  AST_SUSP_NOT_LP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[2] |-> !lp_active_o); // R10
endmodule

// File: tb/tb_lp_suspend_ctrl.sv
module tb_lp_suspend_ctrl;
  localparam int DIV_W = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       mode = 2'd2;
  logic             src = 1'b0;
  logic [1:0]       fsel = 2'd2;
  logic [DIV_W-1:0] mdiv = 3'd4;
  logic [DIV_W-1:0] udiv = 3'd1;
  logic             fr = 1'b0;
  logic             dt = 1'b0;

  logic             mclk_src;
  logic [1:0]       hs_fsel;
  logic [DIV_W-1:0] mclk_div, ulp_div;
  logic             pd_en, lp_act;
  logic [2:0]       status;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lp_suspend_ctrl #(.DIV_W(DIV_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .base_mode_i(mode), .cfg_src_i(src),
    .cfg_fsel_i(fsel), .cfg_mdiv_i(mdiv), .cfg_udiv_i(udiv),
    .fast_req_i(fr), .dma_trig_i(dt), .mclk_src_o(mclk_src),
    .hsosc_fsel_o(hs_fsel), .mclk_div_o(mclk_div), .ulp_div_o(ulp_div),
    .pd_mem_en_o(pd_en), .lp_active_o(lp_act), .status_o(status)
  );

  function automatic logic [13:0] pk(input logic s, input logic [1:0] f,
                                     input logic [2:0] m, input logic [2:0] u,
                                     input logic p, input logic l, input logic [2:0] st);
    return {s, f, m, u, p, l, st};
  endfunction

  function automatic logic [13:0] obs();
    return {mclk_src, hs_fsel, mclk_div, ulp_div, pd_en, lp_act, status};
  endfunction

  task automatic chk(input string req, input logic [13:0] exp);
    n_chk++;
    if (obs() !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, obs(), exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic s, input logic [1:0] f,
                         input logic [2:0] md, input logic [2:0] ud);
    mode = m; src = s; fsel = f; mdiv = md; udiv = ud;
  endtask

  task automatic t_reset();
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    chk("R12 reset stop", pk(1'b0, 2'd2, 3'd4, 3'd1, 1'b0, 1'b1, 3'b000));
    set_cfg(2'd0, 1'b1, 2'd1, 3'd2, 3'd3);
    cyc(1);
    chk("R12 reset run", pk(1'b1, 2'd1, 3'd2, 3'd3, 1'b1, 1'b0, 3'b000));
  endtask

  task automatic t_fast_stop();
    set_cfg(2'd2, 1'b0, 2'd2, 3'd4, 3'd1);
    cyc(1);
    fr = 1'b1;
    cyc(1);
    chk("R8 one edge after request", pk(1'b0, 2'd2, 3'd4, 3'd1, 1'b0, 1'b1, 3'b000));
    cyc(3);
    chk("R1 R2 R10 fast in stop", pk(1'b1, 2'd0, 3'd0, 3'd0, 1'b0, 1'b0, 3'b101));
    fr = 1'b0;
    cyc(3);
    chk("R9 restore cycle", pk(1'b0, 2'd2, 3'd4, 3'd1, 1'b0, 1'b0, 3'b000));
    cyc(1);
    chk("R9 lp re-entered", pk(1'b0, 2'd2, 3'd4, 3'd1, 1'b0, 1'b1, 3'b000));
  endtask

  task automatic t_fast_run_slow();
    set_cfg(2'd0, 1'b1, 2'd1, 3'd2, 3'd2);
    cyc(1);
    fr = 1'b1;
    cyc(4);
    chk("R3 fast in run hs slow", pk(1'b1, 2'd0, 3'd0, 3'd0, 1'b1, 1'b0, 3'b001));
    mode = 2'd1; src = 1'b0; fsel = 2'd0;
    cyc(1);
    chk("R3 fast in sleep lf", pk(1'b1, 2'd0, 3'd0, 3'd0, 1'b1, 1'b0, 3'b001));
    fr = 1'b0;
    cyc(4);
    chk("R3 release", pk(1'b0, 2'd0, 3'd2, 3'd2, 1'b1, 1'b0, 3'b000));
  endtask

  task automatic t_fast_run_hs32();
    set_cfg(2'd1, 1'b1, 2'd0, 3'd1, 3'd3);
    cyc(1);
    fr = 1'b1;
    cyc(4);
    chk("R4 already 32 MHz", pk(1'b1, 2'd0, 3'd1, 3'd3, 1'b1, 1'b0, 3'b000));
    fr = 1'b0;
    cyc(4);
  endtask

  task automatic t_dma_stop();
    set_cfg(2'd3, 1'b0, 2'd3, 3'd5, 3'd2);
    cyc(1);
    dt = 1'b1;
    cyc(4);
    chk("R5 R10 dma in standby", pk(1'b0, 2'd3, 3'd5, 3'd2, 1'b1, 1'b0, 3'b110));
    src = 1'b1; fsel = 2'd0; mdiv = 3'd0; udiv = 3'd0;
    cyc(2);
    chk("R6 saved clock held", pk(1'b0, 2'd3, 3'd5, 3'd2, 1'b1, 1'b0, 3'b110));
    dt = 1'b0;
    cyc(3);
    chk("R9 restore saved", pk(1'b0, 2'd3, 3'd5, 3'd2, 1'b0, 1'b0, 3'b000));
    cyc(1);
    chk("R9 base live cfg", pk(1'b1, 2'd0, 3'd0, 3'd0, 1'b0, 1'b1, 3'b000));
  endtask

  task automatic t_both();
    set_cfg(2'd2, 1'b0, 2'd1, 3'd6, 3'd7);
    cyc(1);
    fr = 1'b1; dt = 1'b1;
    cyc(4);
    chk("R7 union", pk(1'b1, 2'd0, 3'd0, 3'd0, 1'b1, 1'b0, 3'b111));
    dt = 1'b0;
    cyc(4);
    chk("R2 dma dropped", pk(1'b1, 2'd0, 3'd0, 3'd0, 1'b0, 1'b0, 3'b101));
    fr = 1'b0;
    cyc(4);
    chk("R9 back to stop", pk(1'b0, 2'd1, 3'd6, 3'd7, 1'b0, 1'b1, 3'b000));
  endtask

  task automatic t_dma_run();
    set_cfg(2'd0, 1'b0, 2'd2, 3'd3, 3'd1);
    cyc(1);
    dt = 1'b1;
    cyc(4);
    chk("R11 dma in run", pk(1'b0, 2'd2, 3'd3, 3'd1, 1'b1, 1'b0, 3'b000));
    dt = 1'b0;
    cyc(4);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    t_reset();
    t_fast_stop();
    t_fast_run_slow();
    t_fast_run_hs32();
    t_dma_stop();
    t_both();
    t_dma_run();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule